// File: doc/BRIEF.md
# Program counter and return stack

This block keeps the 13-bit instruction fetch address of a small accumulator-style processor. It advances that address once per instruction cycle. Because fetch and execute overlap, the instruction being executed in a cycle is the word fetched in the cycle before. The decoder reports what that instruction does through one-cycle strobes: jump, call, return, return-from-interrupt, write of the low address byte, or a skip whose condition holds. The block then picks the next fetch address.

An absolute jump or call supplies 11 address bits. The two top bits come from bits 4:3 of the page-latch register. A write of the low byte supplies 8 bits, and the upper five come from page-latch bits 4:0.

Calls and accepted interrupts push a return address onto a hidden, eight-entry circular stack. Both kinds of return pop that stack into the full address.

Any change of flow makes the prefetched word stale. The block marks the following cycle with `flush`, and the decoder must treat the word then in execute as a no-op. The block also ignores its own strobes in that cycle. A global interrupt-enable bit is cleared when an interrupt is taken, and set again by return-from-interrupt.

Top module: `prog_counter`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `fetch_addr` is 0x0000, `flush` is 0 and `int_enable` is 1.
- R2: In a cycle with `flush` low, no strobe, and no accepted interrupt, the next `fetch_addr` is the current one plus one, wrapping from 0x1FFF to 0x0000, and the next `flush` is 0.
- R3: A jump (`br_jump`) makes the next `fetch_addr` equal to {`page_reg`[4:3], `jump_lit`[10:0]} and raises `flush` for one cycle.
- R4: A call (`br_call`) loads the same target as a jump, raises `flush`, and pushes the `fetch_addr` of the call cycle, which is the call's own address plus one.
- R5: A return (`br_ret`) or return-from-interrupt (`br_reti`) loads the most recently pushed address into all 13 bits and raises `flush`. Return-from-interrupt also sets `int_enable` to 1.
- R6: A low-byte write (`low_write`) makes the next `fetch_addr` equal to {`page_reg`[4:0], `low_data`[7:0]} and raises `flush`.
- R7: A taken skip (`skip_take`) advances `fetch_addr` by one and raises `flush`, so that the skipped word is discarded.
- R8: In a cycle with `flush` high, all strobes and `irq_req` are ignored, `fetch_addr` advances by one, and `flush` returns to 0. `flush` is therefore never high for two cycles in a row.
- R9: An interrupt request with `int_enable` at 1, in a cycle with `flush` low and no strobe, does three things. It pushes the current `fetch_addr`, moves to vector 0x0004, and clears `int_enable`, with `flush` raised. While `int_enable` is 0 the request is ignored.
- R10: The stack holds eight entries and wraps. A ninth push overwrites the oldest entry, so the ninth pop after nine pushes returns the ninth pushed address again. A pop of an empty stack wraps the same way.
- R11: When several strobes come together, the order of priority is: return or return-from-interrupt first, then call, jump, low-byte write, skip, and an interrupt last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Synchronous reset, active low |
| br_jump | input | 1 | Executing instruction is an absolute jump |
| br_call | input | 1 | Executing instruction is a subroutine call |
| br_ret | input | 1 | Executing instruction is a return, with or without literal |
| br_reti | input | 1 | Executing instruction is a return from interrupt |
| low_write | input | 1 | Executing instruction writes the low address byte |
| skip_take | input | 1 | Executing skip instruction has its condition met |
| irq_req | input | 1 | Pending interrupt request |
| jump_lit | input | 11 | Address literal of a jump or call |
| low_data | input | 8 | Value written to the low address byte |
| page_reg | input | 5 | Page-latch register bits 4:0 |
| fetch_addr | output | 13 | Address of the word fetched this cycle |
| flush | output | 1 | Word now in execute is stale and must act as a no-op |
| int_enable | output | 1 | Global interrupt enable |

## Verification
A wrong pointer or a corrupted stack entry is silent until a return. It then shows as a wrong `fetch_addr` in the cycle after the return, so the bench nests calls up to and past the stack depth and unwinds them. A wrong bubble flag shows within one cycle, as an address that repeats or jumps, or as a `flush` at the wrong time. A wrong priority or page-bit selection shows in the cycle right after the strobe. For these reasons the address, the bubble flag and the enable bit are compared against the reference model after every clock.

// File: rtl/pcseq_pkg.sv
// Package for the program-counter block: next-address action codes and
// default geometry. Assumes one clock edge per instruction cycle.
package pcseq_pkg;

    typedef enum logic [3:0] {
        ACT_STEP,
        ACT_BUBBLE,
        ACT_JUMP,
        ACT_CALL,
        ACT_RET,
        ACT_RETI,
        ACT_LOWSET,
        ACT_SKIP,
        ACT_IRQ
    } pc_act_e;

    localparam int DEF_PC_W    = 13;
    localparam int DEF_LIT_W   = 11;
    localparam int DEF_LOW_W   = 8;
    localparam int DEF_DEPTH   = 8;
    localparam int DEF_RST_VEC = 0;
    localparam int DEF_IRQ_VEC = 4;

endpackage

// File: rtl/pcseq_arbiter.sv
// Chooses the single next-address action for this cycle from the decoded
// strobes. Assumes strobes are meaningless while the bubble flag is set.
// Priority: return kinds, call, jump, low write, skip, interrupt.
module pcseq_arbiter
    import pcseq_pkg::*;
(
    input  logic    bubble,
    input  logic    br_jump,
    input  logic    br_call,
    input  logic    br_ret,
    input  logic    br_reti,
    input  logic    low_write,
    input  logic    skip_take,
    input  logic    irq_req,
    input  logic    int_enable,
    output pc_act_e act
);

    // Fixed-priority selection of the action
    always_comb begin
        if (bubble)                     act = ACT_BUBBLE;
        else if (br_reti)               act = ACT_RETI;
        else if (br_ret)                act = ACT_RET;
        else if (br_call)               act = ACT_CALL;
        else if (br_jump)               act = ACT_JUMP;
        else if (low_write)             act = ACT_LOWSET;
        else if (skip_take)             act = ACT_SKIP;
        else if (irq_req && int_enable) act = ACT_IRQ;
        else                            act = ACT_STEP;
    end

endmodule

// File: rtl/pcseq_target.sv
// Forms the next fetch address for a chosen action. Jump targets take their
// top bits from a slice of the page latch. Low-byte writes take every bit
// above the low byte from it. Purely combinational.
module pcseq_target
    import pcseq_pkg::*;
#(
    parameter int PC_W    = DEF_PC_W,
    parameter int LIT_W   = DEF_LIT_W,
    parameter int LOW_W   = DEF_LOW_W,
    parameter int IRQ_VEC = DEF_IRQ_VEC,
    localparam int PG_W     = PC_W - LOW_W,
    localparam int JMP_BITS = PC_W - LIT_W,
    localparam int JMP_OFS  = LIT_W - LOW_W
) (
    input  pc_act_e          act,
    input  logic [PC_W-1:0]  pc,
    input  logic [LIT_W-1:0] jump_lit,
    input  logic [LOW_W-1:0] low_data,
    input  logic [PG_W-1:0]  page_reg,
    input  logic [PC_W-1:0]  stack_top,
    output logic [PC_W-1:0]  next_pc
);

    logic [PC_W-1:0] pc_inc;
    logic [PC_W-1:0] far_tgt;
    logic [PC_W-1:0] low_tgt;

    assign pc_inc  = pc + PC_W'(1);
    assign far_tgt = {page_reg[JMP_OFS +: JMP_BITS], jump_lit};
    assign low_tgt = {page_reg, low_data};

    // Select the address source for the action
    always_comb begin
        case (act)
            ACT_JUMP, ACT_CALL: next_pc = far_tgt;
            ACT_RET, ACT_RETI:  next_pc = stack_top;
            ACT_LOWSET:         next_pc = low_tgt;
            ACT_IRQ:            next_pc = PC_W'(IRQ_VEC);
            default:            next_pc = pc_inc;
        endcase
    end

endmodule

// File: rtl/pcseq_stack.sv
// Hidden circular return-address stack. Push and pop are never asserted
// together. The pointer wraps, so overflow overwrites the oldest entry and
// underflow reads the newest slot again. Non-power-of-two depths use an
// explicit wrap.
module pcseq_stack #(
    parameter int W     = 13,
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] sp;
    logic [PTR_W-1:0] sp_inc;
    logic [PTR_W-1:0] sp_dec;

    generate
        if ((1 << PTR_W) == DEPTH) begin : g_pow2
            assign sp_inc = sp + PTR_W'(1);
            assign sp_dec = sp - PTR_W'(1);
        end else begin : g_mod
            assign sp_inc = (sp == PTR_W'(DEPTH - 1)) ? '0 : sp + PTR_W'(1);
            assign sp_dec = (sp == '0) ? PTR_W'(DEPTH - 1) : sp - PTR_W'(1);
        end
    endgenerate

    assign top = mem[sp_dec];

    // Write the pushed address and move the pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[sp] <= din;
            sp      <= sp_inc;
        end else if (pop) begin
            sp <= sp_dec;
        end
    end

endmodule

// File: rtl/prog_counter.sv
// Program counter with hidden return stack. Each clock is one instruction
// cycle. Strobes describe the instruction in execute, which is the word
// fetched one cycle earlier. Any change of flow raises flush for the next
// cycle, and that cycle's strobes are ignored. Global interrupt enable
// leaves reset at INT_EN_RST.
module prog_counter
    import pcseq_pkg::*;
#(
    parameter int   PC_W       = DEF_PC_W,
    parameter int   LIT_W      = DEF_LIT_W,
    parameter int   LOW_W      = DEF_LOW_W,
    parameter int   DEPTH      = DEF_DEPTH,
    parameter int   RST_VEC    = DEF_RST_VEC,
    parameter int   IRQ_VEC    = DEF_IRQ_VEC,
    parameter logic INT_EN_RST = 1'b1,
    localparam int  PG_W       = PC_W - LOW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             br_jump,
    input  logic             br_call,
    input  logic             br_ret,
    input  logic             br_reti,
    input  logic             low_write,
    input  logic             skip_take,
    input  logic             irq_req,
    input  logic [LIT_W-1:0] jump_lit,
    input  logic [LOW_W-1:0] low_data,
    input  logic [PG_W-1:0]  page_reg,
    output logic [PC_W-1:0]  fetch_addr,
    output logic             flush,
    output logic             int_enable
);

    pc_act_e         act;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] next_pc;
    logic [PC_W-1:0] stack_top;
    logic            bubble_q;
    logic            ie_q;
    logic            push_en;
    logic            pop_en;
    logic            flush_next;

    pcseq_arbiter u_arb (
        .bubble     (bubble_q),
        .br_jump    (br_jump),
        .br_call    (br_call),
        .br_ret     (br_ret),
        .br_reti    (br_reti),
        .low_write  (low_write),
        .skip_take  (skip_take),
        .irq_req    (irq_req),
        .int_enable (ie_q),
        .act        (act)
    );

    pcseq_target #(
        .PC_W    (PC_W),
        .LIT_W   (LIT_W),
        .LOW_W   (LOW_W),
        .IRQ_VEC (IRQ_VEC)
    ) u_tgt (
        .act       (act),
        .pc        (pc_q),
        .jump_lit  (jump_lit),
        .low_data  (low_data),
        .page_reg  (page_reg),
        .stack_top (stack_top),
        .next_pc   (next_pc)
    );

    pcseq_stack #(
        .W     (PC_W),
        .DEPTH (DEPTH)
    ) u_stk (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_en),
        .pop   (pop_en),
        .din   (pc_q),
        .top   (stack_top)
    );

    // Decode the stack and bubble controls from the action
    always_comb begin
        push_en    = (act == ACT_CALL) || (act == ACT_IRQ);
        pop_en     = (act == ACT_RET)  || (act == ACT_RETI);
        flush_next = !((act == ACT_STEP) || (act == ACT_BUBBLE));
    end

    // Register the fetch address, bubble flag and interrupt enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= PC_W'(RST_VEC);
            bubble_q <= 1'b0;
            ie_q     <= INT_EN_RST;
        end else begin
            pc_q     <= next_pc;
            bubble_q <= flush_next;
            if (act == ACT_IRQ)       ie_q <= 1'b0;
            else if (act == ACT_RETI) ie_q <= 1'b1;
        end
    end

    assign fetch_addr = pc_q;
    assign flush      = bubble_q;
    assign int_enable = ie_q;

endmodule

// File: rtl/pcseq_chk.sv
// Checker for prog_counter: relates strobes to the fetch address, bubble
// flag and interrupt enable on the following cycle. Observes ports only.
module pcseq_chk #(
    parameter int PC_W    = 13,
    parameter int LIT_W   = 11,
    parameter int LOW_W   = 8,
    parameter int IRQ_VEC = 4,
    localparam int PG_W     = PC_W - LOW_W,
    localparam int JMP_BITS = PC_W - LIT_W,
    localparam int JMP_OFS  = LIT_W - LOW_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             br_jump,
    input logic             br_call,
    input logic             br_ret,
    input logic             br_reti,
    input logic             low_write,
    input logic             skip_take,
    input logic             irq_req,
    input logic [LIT_W-1:0] jump_lit,
    input logic [LOW_W-1:0] low_data,
    input logic [PG_W-1:0]  page_reg,
    input logic [PC_W-1:0]  fetch_addr,
    input logic             flush,
    input logic             int_enable
);

    logic any_flow;
    assign any_flow = br_jump | br_call | br_ret | br_reti | low_write | skip_take;

    AST_BUBBLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !flush); // R8
    AST_BUBBLE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> fetch_addr == PC_W'($past(fetch_addr) + 1'b1)); // R8
    AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !any_flow && !(irq_req && int_enable))
        |=> (!flush && fetch_addr == PC_W'($past(fetch_addr) + 1'b1))); // R2
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && br_jump && !br_call && !br_ret && !br_reti)
        |=> (flush && fetch_addr == {$past(page_reg[JMP_OFS +: JMP_BITS]), $past(jump_lit)})); // R3
    AST_LOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && low_write && !br_jump && !br_call && !br_ret && !br_reti)
        |=> (flush && fetch_addr == {$past(page_reg), $past(low_data)})); // R6
    AST_SKIP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && skip_take && !low_write && !br_jump && !br_call && !br_ret && !br_reti)
        |=> (flush && fetch_addr == PC_W'($past(fetch_addr) + 1'b1))); // R7
    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !any_flow && irq_req && int_enable)
        |=> (flush && !int_enable && fetch_addr == PC_W'(IRQ_VEC))); // R9
    AST_RETI_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && br_reti) |=> (flush && int_enable)); // R5

endmodule

bind prog_counter pcseq_chk #(
    .PC_W    (PC_W),
    .LIT_W   (LIT_W),
    .LOW_W   (LOW_W),
    .IRQ_VEC (IRQ_VEC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_jump    (br_jump),
    .br_call    (br_call),
    .br_ret     (br_ret),
    .br_reti    (br_reti),
    .low_write  (low_write),
    .skip_take  (skip_take),
    .irq_req    (irq_req),
    .jump_lit   (jump_lit),
    .low_data   (low_data),
    .page_reg   (page_reg),
    .fetch_addr (fetch_addr),
    .flush      (flush),
    .int_enable (int_enable)
);

// File: tb/prog_counter_test.sv
`timescale 1ns/1ps
module prog_counter_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_jump = 0, br_call = 0, br_ret = 0, br_reti = 0;
    logic        low_write = 0, skip_take = 0, irq_req = 0;
    logic [10:0] jump_lit = '0;
    logic [7:0]  low_data = '0;
    logic [4:0]  page_reg = '0;
    logic [12:0] fetch_addr;
    logic        flush, int_enable;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    int   m_pc = 0;
    bit   m_fl = 0;
    bit   m_ie = 1;
    int   m_stk[8];
    int   m_sp = 0;

    always #2.5 clk = ~clk;

    prog_counter uut (
        .clk(clk), .rst_n(rst_n), .br_jump(br_jump), .br_call(br_call),
        .br_ret(br_ret), .br_reti(br_reti), .low_write(low_write),
        .skip_take(skip_take), .irq_req(irq_req), .jump_lit(jump_lit),
        .low_data(low_data), .page_reg(page_reg), .fetch_addr(fetch_addr),
        .flush(flush), .int_enable(int_enable)
    );

    task automatic report_end();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog (all R): actual=timeout expected=completion");
        report_end();
    end

    task automatic m_push(input int v);
        m_stk[m_sp] = v;
        m_sp = (m_sp + 1) % 8;
    endtask

    task automatic m_pop(output int v);
        m_sp = (m_sp + 7) % 8;
        v = m_stk[m_sp];
    endtask

    // one instruction cycle of the reference, from current inputs
    task automatic m_step();
        int v;
        if (m_fl) begin
            m_pc = (m_pc + 1) % 8192; m_fl = 0;
        end else if (br_ret || br_reti) begin
            m_pop(v); m_pc = v; m_fl = 1;
            if (br_reti) m_ie = 1;
        end else if (br_call) begin
            m_push(m_pc); m_pc = int'(page_reg[4:3]) * 2048 + int'(jump_lit); m_fl = 1;
        end else if (br_jump) begin
            m_pc = int'(page_reg[4:3]) * 2048 + int'(jump_lit); m_fl = 1;
        end else if (low_write) begin
            m_pc = int'(page_reg) * 256 + int'(low_data); m_fl = 1;
        end else if (skip_take) begin
            m_pc = (m_pc + 1) % 8192; m_fl = 1;
        end else if (irq_req && m_ie) begin
            m_push(m_pc); m_pc = 4; m_ie = 0; m_fl = 1;
        end else begin
            m_pc = (m_pc + 1) % 8192; m_fl = 0;
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (int'(fetch_addr) != m_pc) begin
            fails++;
            $display("FAIL %s: fetch_addr actual=%h expected=%h", tag, fetch_addr, m_pc);
        end
        checks++;
        if (flush != m_fl) begin
            fails++;
            $display("FAIL %s: flush actual=%0b expected=%0b", tag, flush, m_fl);
        end
        checks++;
        if (int_enable != m_ie) begin
            fails++;
            $display("FAIL %s: int_enable actual=%0b expected=%0b", tag, int_enable, m_ie);
        end
    endtask

    // apply current inputs for one cycle, then compare and clear strobes
    task automatic tick(input string tag);
        m_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
        br_jump = 0; br_call = 0; br_ret = 0; br_reti = 0;
        low_write = 0; skip_take = 0; irq_req = 0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_stk[i] = 0;
        // R1: reset state, with noise on the strobes
        br_jump = 1; irq_req = 1;
        repeat (3) @(negedge clk);
        compare("R1");
        br_jump = 0; irq_req = 0;
        rst_n = 1;
        compare("R1");

        // R2: plain sequencing
        repeat (3) tick("R2");

        // R3: jump with page bits 4:3 = 11, then a bubble that ignores strobes (R8)
        br_jump = 1; jump_lit = 11'h123; page_reg = 5'h18; tick("R3");
        br_call = 1; irq_req = 1; jump_lit = 11'h000; tick("R8");
        tick("R2");

        // R4: nested calls, R5: returns unwind in reverse order
        br_call = 1; jump_lit = 11'h050; page_reg = 5'h00; tick("R4");
        tick("R4");
        br_call = 1; jump_lit = 11'h2AA; page_reg = 5'h08; tick("R4");
        tick("R4");
        tick("R2");
        br_ret = 1; tick("R5");
        tick("R5");
        br_ret = 1; tick("R5");
        tick("R5");

        // R6: low-byte write with all page bits
        low_write = 1; low_data = 8'hAB; page_reg = 5'h1F; tick("R6");
        tick("R6");

        // R7: taken skip
        skip_take = 1; tick("R7");
        tick("R7");
        tick("R2");

        // R9: interrupt accepted, then ignored while disabled, R5: reti re-enables
        irq_req = 1; tick("R9");
        tick("R9");
        irq_req = 1; tick("R9");
        br_reti = 1; tick("R5");
        tick("R5");

        // R11: priority among simultaneous strobes
        br_call = 1; jump_lit = 11'h111; page_reg = 5'h00; tick("R11");
        tick("R11");
        br_ret = 1; br_call = 1; br_jump = 1; low_write = 1; skip_take = 1; irq_req = 1; tick("R11");
        tick("R11");
        br_call = 1; br_jump = 1; low_write = 1; jump_lit = 11'h222; tick("R11");
        tick("R11");
        br_jump = 1; low_write = 1; skip_take = 1; jump_lit = 11'h333; page_reg = 5'h10; tick("R11");
        tick("R11");
        low_write = 1; skip_take = 1; low_data = 8'h40; page_reg = 5'h02; tick("R11");
        tick("R11");
        skip_take = 1; irq_req = 1; tick("R11");
        tick("R11");
        br_ret = 1; tick("R11");
        tick("R11");

        // R10: nine nested calls, then ten returns (wrap over and under)
        for (int i = 0; i < 9; i++) begin
            br_call = 1; jump_lit = 11'(16 * i + 8); page_reg = 5'(i); tick("R10");
            tick("R10");
        end
        for (int i = 0; i < 10; i++) begin
            br_ret = 1; tick("R10");
            tick("R10");
        end

        // R2: wrap of the address at the top
        low_write = 1; low_data = 8'hFE; page_reg = 5'h1F; tick("R6");
        tick("R2");
        tick("R2");
        tick("R2");

        report_end();
    end

endmodule